// File: doc/BRIEF.md
# Double-Width Integer Divider with Range Fault

This block divides a dividend of twice the operand width by a divisor of the operand width. It returns a quotient and a remainder, or it raises a fault and leaves its result outputs as they were. Each operation picks its own operand width (8, 16 or 32 bits) and chooses signed or unsigned arithmetic. A start pulse launches an operation. `busy` stays high while it runs, and `done` pulses for one cycle when it ends. The result is valid in that cycle, or `div_fault` is high instead.

The core is a restoring shift-subtract loop that produces one quotient bit per clock, so an operation takes as many iterations as the operand width. Signed operands are first turned into magnitudes. The loop divides those magnitudes, and the signs are put back at the end. There are three fault causes: a zero divisor, a dividend high half that is already too large for the divisor (found before the loop starts), and a signed quotient outside the range of the operand width. Flags are not produced. The caller is responsible for writing `new_lo` and `new_hi` back to its register halves.

Top module: `wdiv_top`

## Requirements
- R1: A divisor whose low N bits are all zero ends the operation with `div_fault`=1, and `new_lo`/`new_hi` keep the values they held before the operation.
- R2: In unsigned mode, if the quotient is 2^N or more, the operation ends with `div_fault`=1 and the results are not updated.
- R3: In signed mode, the operation faults when the true quotient is above 2^(N-1)-1 or below -2^(N-1). A quotient of exactly -2^(N-1) is a valid result.
- R4: With `width_sel`=0 (N=8), the dividend is `dvd_lo[15:0]` and `dvd_hi` is ignored. The result is `new_lo[7:0]`=quotient, `new_lo[15:8]`=remainder, and every other result bit is 0.
- R5: With N=16 or 32, the dividend is {`dvd_hi[N-1:0]`,`dvd_lo[N-1:0]`}. `new_lo` gets the zero-extended quotient and `new_hi` gets the zero-extended remainder. Bits above N of the inputs are ignored.
- R6: The `width_sel` encoding is 0 for N=8, 1 for N=16, 2 for N=32, and 3 also selects N=32.
- R7: In signed mode the quotient is truncated toward zero, and a nonzero remainder has the sign of the dividend.
- R8: `done` is high for exactly one cycle per accepted start, and `busy` is low in that cycle.
- R9: A `start` that arrives while `busy` is high is ignored. The operation in flight completes with its own operands, and no extra `done` follows it.
- R10: A zero divisor, or a dividend high-half magnitude at or above the divisor magnitude, is detected when the start is accepted. In that case `done` appears 2 clock edges after the start edge.
- R11: Any other operation runs N iterations, and `done` appears N+2 clock edges after the start edge. This includes operations that end in a signed range fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation (accepted only when not busy) |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| width_sel | input | 2 | Operand width code (see R6) |
| dvd_hi | input | 32 | Dividend upper half |
| dvd_lo | input | 32 | Dividend lower half |
| divisor | input | 32 | Divisor, low N bits used |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_fault | output | 1 | Fault indication, valid with `done` |
| new_lo | output | 32 | Replacement low half (quotient, or packed result for N=8) |
| new_hi | output | 32 | Replacement high half (remainder, zero for N=8) |

## Verification
The hardest case to reach from the ports is the late signed fault. The magnitude division completes without any early overflow, and the fault only appears after the signs are put back: for example, the most negative dividend divided by -1, or a positive quotient of exactly 2^(N-1). Random operands almost never produce it. The stimulus table therefore hand-places these operands at each width, next to the neighbouring case of -2^(N-1) that must be accepted. The same table also covers the early-fault path and the zero-divisor path, and it checks that a faulting operation leaves the previous result in place.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2,
      ST_FLT  = 2'd3
   } wdiv_state_e;

   // Operand width for a width index; index k selects 8 << k bits.
   function automatic int lane_bits(input int idx);
      return 8 << idx;
   endfunction

   // Width index used for a selector code; codes past the last width map to it.
   function automatic int lane_clamp(input int code, input int num_widths);
      return (code >= num_widths) ? num_widths - 1 : code;
   endfunction
endpackage

// File: rtl/wdiv_prep.sv
module wdiv_prep
   import wdiv_pkg::*;
#(
   parameter int NUM_WIDTHS = 3,
   localparam int XLEN = 8 << (NUM_WIDTHS - 1),
   localparam int SW   = $clog2(NUM_WIDTHS),
   localparam int CW   = $clog2(XLEN + 1)
) (
   input  logic            is_signed,
   input  logic [SW-1:0]   lane,
   input  logic [XLEN-1:0] hi_in,
   input  logic [XLEN-1:0] lo_in,
   input  logic [XLEN-1:0] dsr_in,
   output logic [XLEN-1:0] hi_mag,
   output logic [XLEN-1:0] lo_aligned,
   output logic [XLEN-1:0] dsr_mag,
   output logic [CW-1:0]   n_bits,
   output logic            sgn_a,
   output logic            sgn_b,
   output logic            dsr_zero,
   output logic            early_ovf
);
   localparam int NSEL = 1 << SW;

   logic [XLEN-1:0] e_hi  [NSEL];
   logic [XLEN-1:0] e_lo  [NSEL];
   logic [XLEN-1:0] e_dsr [NSEL];
   logic [CW-1:0]   e_n   [NSEL];
   logic [NSEL-1:0] e_sa, e_sb, e_zero;

   for (genvar i = 0; i < NSEL; i++) begin : g_sel
      localparam int K = lane_clamp(i, NUM_WIDTHS);
      localparam int W = lane_bits(K);
      logic [2*W-1:0] num, nmag;
      logic [W-1:0]   dv, dmag;
      logic           na, nb;

      if (K == 0) begin : g_packed
         assign num = lo_in[2*W-1:0];
      end else begin : g_split
         assign num = {hi_in[W-1:0], lo_in[W-1:0]};
      end

      assign dv   = dsr_in[W-1:0];
      assign na   = is_signed & num[2*W-1];
      assign nb   = is_signed & dv[W-1];
      assign nmag = na ? (~num + 1'b1) : num;
      assign dmag = nb ? (~dv + 1'b1) : dv;

      assign e_hi[i]   = XLEN'(nmag[2*W-1:W]);
      assign e_lo[i]   = XLEN'(nmag[W-1:0]) << (XLEN - W);
      assign e_dsr[i]  = XLEN'(dmag);
      assign e_n[i]    = CW'(W);
      assign e_sa[i]   = na;
      assign e_sb[i]   = nb;
      assign e_zero[i] = (dv == '0);
   end

   assign hi_mag     = e_hi[lane];
   assign lo_aligned = e_lo[lane];
   assign dsr_mag    = e_dsr[lane];
   assign n_bits     = e_n[lane];
   assign sgn_a      = e_sa[lane];
   assign sgn_b      = e_sb[lane];
   assign dsr_zero   = e_zero[lane];
   assign early_ovf  = (hi_mag >= dsr_mag);
endmodule

// File: rtl/wdiv_core.sv
module wdiv_core
   import wdiv_pkg::*;
#(
   parameter int NUM_WIDTHS = 3,
   localparam int XLEN = 8 << (NUM_WIDTHS - 1),
   localparam int SW   = $clog2(NUM_WIDTHS),
   localparam int CW   = $clog2(XLEN + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            is_signed,
   input  logic [SW-1:0]   lane,
   input  logic [XLEN-1:0] hi_mag,
   input  logic [XLEN-1:0] lo_aligned,
   input  logic [XLEN-1:0] dsr_mag,
   input  logic [CW-1:0]   n_bits,
   input  logic            sgn_a,
   input  logic            sgn_b,
   input  logic            dsr_zero,
   input  logic            early_ovf,
   output logic            busy,
   output logic            fin,
   output logic            flt,
   output logic [XLEN-1:0] q_mag,
   output logic [XLEN-1:0] r_mag,
   output logic            sgn_l,
   output logic            sa_l,
   output logic            sb_l,
   output logic [SW-1:0]   lane_l
);
   wdiv_state_e     state;
   logic [XLEN-1:0] rem, dsr, lsh, quo;
   logic [CW-1:0]   cnt;
   logic [XLEN:0]   shifted, diff;
   logic            take;
   logic [XLEN-1:0] rem_nx;

   // Shift in the next dividend bit; subtract when the widened value reaches the divisor.
   always_comb begin
      shifted = {rem, lsh[XLEN-1]};
      diff    = shifted - {1'b0, dsr};
      take    = (shifted >= {1'b0, dsr});
      rem_nx  = take ? diff[XLEN-1:0] : shifted[XLEN-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         rem    <= '0;
         dsr    <= '0;
         lsh    <= '0;
         quo    <= '0;
         cnt    <= '0;
         sgn_l  <= 1'b0;
         sa_l   <= 1'b0;
         sb_l   <= 1'b0;
         lane_l <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  sgn_l  <= is_signed;
                  sa_l   <= sgn_a;
                  sb_l   <= sgn_b;
                  lane_l <= lane;
                  if (dsr_zero || early_ovf) begin
                     state <= ST_FLT;
                  end else begin
                     rem   <= hi_mag;
                     dsr   <= dsr_mag;
                     lsh   <= lo_aligned;
                     quo   <= '0;
                     cnt   <= n_bits;
                     state <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               rem <= rem_nx;
               lsh <= lsh << 1;
               quo <= {quo[XLEN-2:0], take};
               cnt <= cnt - 1'b1;
               if (cnt == CW'(1)) state <= ST_FIN;
            end
            ST_FIN, ST_FLT: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy  = (state != ST_IDLE);
   assign fin   = (state == ST_FIN);
   assign flt   = (state == ST_FLT);
   assign q_mag = quo;
   assign r_mag = rem;
endmodule

// File: rtl/wdiv_post.sv
module wdiv_post
   import wdiv_pkg::*;
#(
   parameter int NUM_WIDTHS = 3,
   localparam int XLEN = 8 << (NUM_WIDTHS - 1),
   localparam int SW   = $clog2(NUM_WIDTHS)
) (
   input  logic            sgn,
   input  logic            sa,
   input  logic            sb,
   input  logic [SW-1:0]   lane,
   input  logic [XLEN-1:0] q_mag,
   input  logic [XLEN-1:0] r_mag,
   output logic            range_ovf,
   output logic [XLEN-1:0] res_lo,
   output logic [XLEN-1:0] res_hi
);
   localparam int NSEL = 1 << SW;

   logic [XLEN-1:0] e_lo [NSEL];
   logic [XLEN-1:0] e_hi [NSEL];
   logic [NSEL-1:0] e_ovf;

   for (genvar i = 0; i < NSEL; i++) begin : g_sel
      localparam int K = lane_clamp(i, NUM_WIDTHS);
      localparam int W = lane_bits(K);
      logic [W-1:0] qm, rm, qs, rs, lim;
      logic         neg_q;

      assign qm    = q_mag[W-1:0];
      assign rm    = r_mag[W-1:0];
      assign lim   = {1'b1, {(W-1){1'b0}}};
      assign neg_q = sgn & (sa ^ sb);
      // Negative results may reach -2^(W-1); positive ones must stay below 2^(W-1).
      assign e_ovf[i] = sgn & (neg_q ? (qm > lim) : (qm >= lim));
      assign qs    = neg_q ? (~qm + 1'b1) : qm;
      assign rs    = (sgn & sa) ? (~rm + 1'b1) : rm;

      if (K == 0) begin : g_packed
         assign e_lo[i] = XLEN'({rs, qs});
         assign e_hi[i] = '0;
      end else begin : g_split
         assign e_lo[i] = XLEN'(qs);
         assign e_hi[i] = XLEN'(rs);
      end
   end

   assign range_ovf = e_ovf[lane];
   assign res_lo    = e_lo[lane];
   assign res_hi    = e_hi[lane];
endmodule

// File: rtl/wdiv_top.sv
module wdiv_top
   import wdiv_pkg::*;
#(
   parameter int NUM_WIDTHS = 3,
   localparam int XLEN = 8 << (NUM_WIDTHS - 1),
   localparam int SW   = $clog2(NUM_WIDTHS),
   localparam int CW   = $clog2(XLEN + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            is_signed,
   input  logic [SW-1:0]   width_sel,
   input  logic [XLEN-1:0] dvd_hi,
   input  logic [XLEN-1:0] dvd_lo,
   input  logic [XLEN-1:0] divisor,
   output logic            busy,
   output logic            done,
   output logic            div_fault,
   output logic [XLEN-1:0] new_lo,
   output logic [XLEN-1:0] new_hi
);
   if (NUM_WIDTHS < 2 || NUM_WIDTHS > 4) begin : g_bad_cfg
      $error("wdiv_top: NUM_WIDTHS must lie in 2..4");
   end

   logic [XLEN-1:0] hi_mag, lo_aligned, dsr_mag, q_mag, r_mag, p_lo, p_hi;
   logic [CW-1:0]   n_bits;
   logic            sgn_a, sgn_b, dsr_zero, early_ovf;
   logic            fin, flt, sgn_l, sa_l, sb_l, range_ovf;
   logic [SW-1:0]   lane_l;

   wdiv_prep #(.NUM_WIDTHS(NUM_WIDTHS)) u_prep (
      .is_signed (is_signed),
      .lane      (width_sel),
      .hi_in     (dvd_hi),
      .lo_in     (dvd_lo),
      .dsr_in    (divisor),
      .hi_mag    (hi_mag),
      .lo_aligned(lo_aligned),
      .dsr_mag   (dsr_mag),
      .n_bits    (n_bits),
      .sgn_a     (sgn_a),
      .sgn_b     (sgn_b),
      .dsr_zero  (dsr_zero),
      .early_ovf (early_ovf)
   );

   wdiv_core #(.NUM_WIDTHS(NUM_WIDTHS)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .is_signed (is_signed),
      .lane      (width_sel),
      .hi_mag    (hi_mag),
      .lo_aligned(lo_aligned),
      .dsr_mag   (dsr_mag),
      .n_bits    (n_bits),
      .sgn_a     (sgn_a),
      .sgn_b     (sgn_b),
      .dsr_zero  (dsr_zero),
      .early_ovf (early_ovf),
      .busy      (busy),
      .fin       (fin),
      .flt       (flt),
      .q_mag     (q_mag),
      .r_mag     (r_mag),
      .sgn_l     (sgn_l),
      .sa_l      (sa_l),
      .sb_l      (sb_l),
      .lane_l    (lane_l)
   );

   wdiv_post #(.NUM_WIDTHS(NUM_WIDTHS)) u_post (
      .sgn      (sgn_l),
      .sa       (sa_l),
      .sb       (sb_l),
      .lane     (lane_l),
      .q_mag    (q_mag),
      .r_mag    (r_mag),
      .range_ovf(range_ovf),
      .res_lo   (p_lo),
      .res_hi   (p_hi)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done      <= 1'b0;
         div_fault <= 1'b0;
         new_lo    <= '0;
         new_hi    <= '0;
      end else begin
         done      <= fin | flt;
         div_fault <= flt | (fin & range_ovf);
         if (fin && !range_ovf) begin
            new_lo <= p_lo;
            new_hi <= p_hi;
         end
      end
   end
endmodule

// File: rtl/wdiv_checks.sv
module wdiv_checks #(
   parameter int NUM_WIDTHS = 3,
   localparam int XLEN = 8 << (NUM_WIDTHS - 1),
   localparam int SW   = $clog2(NUM_WIDTHS)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic [SW-1:0]   width_sel,
   input logic [XLEN-1:0] divisor,
   input logic            busy,
   input logic            done,
   input logic            div_fault,
   input logic [XLEN-1:0] new_lo,
   input logic [XLEN-1:0] new_hi
);
   logic zero_in;
   always_comb begin
      int w;
      w = 8 << ((int'(width_sel) >= NUM_WIDTHS) ? NUM_WIDTHS - 1 : int'(width_sel));
      zero_in = ((divisor << (XLEN - w)) == '0);
   end

   p_zero_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && zero_in) |-> ##2 (done && div_fault));

   p_fault_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && div_fault) |-> ($stable(new_lo) && $stable(new_hi)));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_busy_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !busy);
endmodule

bind wdiv_top wdiv_checks #(.NUM_WIDTHS(NUM_WIDTHS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .width_sel(width_sel),
   .divisor  (divisor),
   .busy     (busy),
   .done     (done),
   .div_fault(div_fault),
   .new_lo   (new_lo),
   .new_hi   (new_hi)
);

// File: tb/wdiv_top_test.sv
`timescale 1ns/1ps
module wdiv_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        is_signed = 1'b0;
   logic [1:0]  width_sel = '0;
   logic [31:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
   logic        busy, done, div_fault;
   logic [31:0] new_lo, new_hi;

   int total = 0;
   int bad   = 0;
   logic [31:0] last_lo = '0, last_hi = '0;

   always #4 clk = ~clk;

   wdiv_top uut (
      .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
      .width_sel(width_sel), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
      .busy(busy), .done(done), .div_fault(div_fault), .new_lo(new_lo), .new_hi(new_hi)
   );

   // {signed, width code, high half, low half, divisor}
   localparam int NV = 16;
   localparam logic [98:0] VEC [NV] = '{
      {1'b0, 2'd0, 32'hDEADBEEF, 32'hABCD0064, 32'hFFFFFF07}, // R4 upper bits ignored
      {1'b0, 2'd0, 32'h0, 32'h00001234, 32'h00000010},        // R2 early
      {1'b0, 2'd0, 32'h0, 32'h00000FFF, 32'h00000010},        // R4 max quotient
      {1'b1, 2'd0, 32'h0, 32'h0000FF00, 32'h00000002},        // R3 -128 allowed
      {1'b1, 2'd0, 32'h0, 32'h00000100, 32'h00000002},        // R3 +128 faults
      {1'b1, 2'd0, 32'h0, 32'h0000FFF9, 32'h00000002},        // R7 -7/2
      {1'b0, 2'd1, 32'hFFFF0001, 32'h00000000, 32'h00000002}, // R5
      {1'b0, 2'd1, 32'h0, 32'h00001234, 32'hABCD0000},        // R1 zero low half
      {1'b1, 2'd1, 32'h0000FFFF, 32'h00008000, 32'h0000FFFF}, // R3 min / -1
      {1'b1, 2'd1, 32'h0000FFFF, 32'h00008000, 32'h00000001}, // R3 min / 1
      {1'b0, 2'd2, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'hFFFFFFFF}, // R5 largest
      {1'b0, 2'd2, 32'h0, 32'h00000064, 32'h00000000},        // R1
      {1'b1, 2'd2, 32'hFFFFFFFF, 32'h80000000, 32'hFFFFFFFF}, // R3 min / -1
      {1'b1, 2'd2, 32'h0, 32'h00000007, 32'hFFFFFFFE},        // R7 7/-2
      {1'b0, 2'd3, 32'h00000001, 32'h00000000, 32'h00000004}, // R6 code 3
      {1'b1, 2'd2, 32'hFFFFFFFF, 32'hFFFFFFF9, 32'h00000002}  // R7 -7/2
   };

   // Returns {early, fault, new_hi, new_lo}
   function automatic logic [65:0] ref_div(input bit sg, input logic [1:0] ws,
                                           input logic [31:0] h, input logic [31:0] l,
                                           input logic [31:0] d);
      int n;
      logic [63:0] num, m2, m1, dd, mn, md, q, r, lim, qs, rs;
      bit sa, sb, fl, early;
      n  = (ws == 2'd0) ? 8 : (ws == 2'd1) ? 16 : 32;
      m2 = (64'd1 << (2 * n)) - 1;
      m1 = (64'd1 << n) - 1;
      if (n == 8) num = {48'd0, l[15:0]};
      else if (n == 16) num = {32'd0, h[15:0], l[15:0]};
      else num = {h, l};
      dd = {32'd0, d} & m1;
      if (dd == 0) return {1'b1, 1'b1, 64'd0};
      sa = sg && num[2*n-1];
      sb = sg && dd[n-1];
      mn = sa ? ((~num + 1) & m2) : num;
      md = sb ? ((~dd + 1) & m1) : dd;
      early = ((mn >> n) >= md);
      q = mn / md;
      r = mn % md;
      lim = 64'd1 << (n - 1);
      if (!sg) fl = (q > m1);
      else fl = (sa ^ sb) ? (q > lim) : (q >= lim);
      qs = ((sa ^ sb) ? (~q + 1) : q) & m1;
      rs = (sa ? (~r + 1) : r) & m1;
      if (n == 8) return {early, fl, 32'd0, 16'd0, rs[7:0], qs[7:0]};
      return {early, fl, rs[31:0], qs[31:0]};
   endfunction

   function automatic string tag_of(input bit sg, input logic [1:0] ws,
                                    input logic [31:0] d, input bit fl);
      int n;
      n = (ws == 2'd0) ? 8 : (ws == 2'd1) ? 16 : 32;
      if ((({32'd0, d} & ((64'd1 << n) - 1))) == 0) return "R1";
      if (fl && !sg) return "R2";
      if (fl) return "R3";
      if (sg) return "R7";
      if (ws == 2'd3) return "R6";
      if (n == 8) return "R4";
      return "R5";
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(input bit sg, input logic [1:0] ws, input logic [31:0] h,
                         input logic [31:0] l, input logic [31:0] d, output int lat);
      @(negedge clk);
      start = 1'b1; is_signed = sg; width_sel = ws; dvd_hi = h; dvd_lo = l; divisor = d;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic do_vec(input bit sg, input logic [1:0] ws, input logic [31:0] h,
                         input logic [31:0] l, input logic [31:0] d);
      logic [65:0] e;
      int lat, n, elat;
      string t;
      e = ref_div(sg, ws, h, l, d);
      n = (ws == 2'd0) ? 8 : (ws == 2'd1) ? 16 : 32;
      t = tag_of(sg, ws, d, e[64]);
      run_op(sg, ws, h, l, d, lat);
      elat = e[65] ? 2 : n + 2;
      check(lat == elat, e[65] ? "R10" : "R11", 64'(lat), 64'(elat));
      check(div_fault == e[64], t, 64'(div_fault), 64'(e[64]));
      if (e[64]) begin
         check({new_hi, new_lo} == {last_hi, last_lo}, t, {new_hi, new_lo}, {last_hi, last_lo});
      end else begin
         check({new_hi, new_lo} == e[63:0], t, {new_hi, new_lo}, e[63:0]);
         last_hi = e[63:32];
         last_lo = e[31:0];
      end
   endtask

   bit finished = 1'b0;

   initial begin
      #(8 * 150000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int lat, cnt;
      repeat (3) @(negedge clk);
      // reset state (R8)
      check({busy, done, div_fault} == 3'b000, "R8", 64'({busy, done, div_fault}), 64'd0);
      check({new_hi, new_lo} == 64'd0, "R5", {new_hi, new_lo}, 64'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         do_vec(VEC[i][98], VEC[i][97:96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);
      end

      // R8: done lasts one cycle, busy low with it
      run_op(1'b0, 2'd1, 32'd0, 32'd5000, 32'd9, lat);
      check(busy == 1'b0, "R8", 64'(busy), 64'd0);
      @(negedge clk);
      check(done == 1'b0, "R8", 64'(done), 64'd0);
      last_lo = 32'd555; last_hi = 32'd5;

      // R9: second start while busy is ignored
      @(negedge clk);
      start = 1'b1; is_signed = 1'b0; width_sel = 2'd2;
      dvd_hi = 32'd0; dvd_lo = 32'd1000; divisor = 32'd7;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check(busy == 1'b1, "R9", 64'(busy), 64'd1);
      start = 1'b1; divisor = 32'd0; dvd_lo = 32'd3;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      check(div_fault == 1'b0, "R9", 64'(div_fault), 64'd0);
      check({new_hi, new_lo} == {32'd6, 32'd142}, "R9", {new_hi, new_lo}, {32'd6, 32'd142});
      cnt = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (done) cnt++;
      end
      check(cnt == 0, "R9", 64'(cnt), 64'd0);
      last_hi = 32'd6; last_lo = 32'd142;

      // random operands across all modes
      for (int k = 0; k < 300; k++) begin
         logic [31:0] h, l, d;
         logic [1:0] ws;
         bit sg;
         h = $urandom; l = $urandom; d = $urandom;
         ws = 2'($urandom % 4);
         sg = 1'($urandom % 2);
         if (k % 2 == 0) h = h >> ($urandom % 33);
         if (k % 5 == 0) d = d >> ($urandom % 33);
         if (k % 7 == 0) d = d | 32'hFFFF8000;
         do_vec(sg, ws, h, l, d);
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule